// File: doc/BRIEF.md
# SMBus Host Transaction Controller

This block is the host side of an SMBus port. Software fills a small byte-addressed register file with a target address (direction in bit 0), a command code and data bytes. It then writes a protocol code to the control register with the start bit set. A sequencer breaks the transaction into byte-level bus operations: start, write a byte and sample the acknowledge, read a byte and return ACK or NACK, and stop. It hands each operation to a bit-level bus engine over a request/done handshake. Results land back in the data registers.

Block transfers pass through a one-byte data port. After every block byte the host raises a byte-done flag and pauses. Software refills or drains the port, then writes 1 to that flag to release the host. On a block read, software marks the final byte by setting bit 5 of the control register. The host NACKs that byte and then stops. A status register reports busy, completion, device error (missing acknowledge), bus collision and failure. All of these except busy are write-1-to-clear.

Top module: `smbus_host`

## Requirements
- R1: Registers sit at byte offsets status 0, control 2, command 3, address 4, data0 5, data1 6, block port 7, PEC byte 8 and auxiliary control 13. Control reads back bits 5:0 (start reads 0) and auxiliary control reads back bit 0 only. Every register is 0 after reset.
- R2: Writing control with bit 6 set starts a transaction only when busy is clear and the device-error, collision and failed flags are all clear. Otherwise the write starts nothing and no bus operation is issued.
- R3: Protocol code 0 (quick) issues start, the address register byte unchanged, then stop.
- R4: Protocol code 0x04 (byte) with address bit 0 = 0 sends start, address, command, stop. With address bit 0 = 1 it sends start, address, then reads one byte with NACK into data0, then stop.
- R5: Codes 0x08 (byte-data) and 0x0C (word) send the address with bit 0 forced to 0, then the command. A write sends data0 (then data1 for word). A read issues a repeated start and the address with bit 0 forced to 1, then reads into data0 (then data1 for word). The last byte read is NACKed and all earlier bytes are ACKed.
- R6: Code 0x14 (block) with address bit 0 = 0 sends data0 clamped to 1..32 as the count byte, then the block port byte. After each data byte it sets byte-done (status bit 7) and waits. Clearing byte-done sends the next block-port byte, or stops after the counted number of bytes.
- R7: A block read sends command, repeated start and read address, then reads a count byte. It stores the count clamped to 1..32 in data0. Each following byte goes to the block port with a byte-done pause. A byte is NACKed, and the transfer stops after its pause, when control bit 5 is set or when it is the last counted byte.
- R8: Status bits are busy 0, complete 1, device error 2, collision 3, failed 4 and byte-done 7. Writing 1 clears bits 1, 2, 3, 4 and 7 individually. Writing bit 0 has no effect.
- R9: On a successful finish, busy falls and complete rises in the same clock cycle.
- R10: A missing acknowledge on any written byte aborts the transfer. The host sends stop, sets device error, clears busy and leaves complete clear.
- R11: A lost-arbitration report on any operation ends the transfer at once with no stop. It sets collision and clears busy.
- R12: A start with an unsupported protocol field (bits 4:2 equal to 4, 6 or 7) sets failed, leaves busy clear and issues no bus operation.
- R13: With auxiliary bit 0 set, every non-quick transaction adds one byte before stop. A write sends the PEC register. A read receives a byte with NACK into the PEC register, and the data byte before it is then ACKed.
- R14: A bus request holds its kind and transmit byte stable until the engine returns done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte offset |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr (combinational) |
| opValid | output | 1 | Byte operation request to the bus engine |
| opKind | output | 2 | 0 start, 1 write byte, 2 read byte, 3 stop |
| opTxByte | output | 8 | Byte to send for a write operation |
| opNack | output | 1 | For a read: 1 drives NACK after the byte |
| opDone | input | 1 | One-cycle completion of the current request |
| opRxByte | input | 8 | Received byte, valid with opDone |
| opAckIn | input | 1 | Target acknowledged the written byte, valid with opDone |
| opLost | input | 1 | Arbitration lost, valid with opDone |

## Verification
The bench goes after three groups of corner cases.

- Block count edges: a count of 0 must become one byte and a count of 40 must become 32. A design that skipped the clamp would send a raw count and keep running for the wrong number of bytes.
- Block read endings: one ending comes from the control flag, another from the counted length. A design that sampled the flag at the wrong time would ACK the final byte or read one byte too many, and the bench's operation-by-operation comparison flags it.
- Start gating and error paths: starts are attempted while busy, while error flags are pending and with unsupported codes. Any operation issued there is an unexpected request. A NACK or lost arbitration at address time must end the transfer with the right flag and, for a lost bus, with no stop.

// File: rtl/smbus_host_pkg.sv
`timescale 1ns/1ps
package smbus_host_pkg;

  localparam int unsigned REG_AW = 4;

  // register byte offsets
  localparam logic [REG_AW-1:0] OFF_STS  = 4'd0;
  localparam logic [REG_AW-1:0] OFF_CTL  = 4'd2;
  localparam logic [REG_AW-1:0] OFF_CMD  = 4'd3;
  localparam logic [REG_AW-1:0] OFF_ADR  = 4'd4;
  localparam logic [REG_AW-1:0] OFF_D0   = 4'd5;
  localparam logic [REG_AW-1:0] OFF_D1   = 4'd6;
  localparam logic [REG_AW-1:0] OFF_BLK  = 4'd7;
  localparam logic [REG_AW-1:0] OFF_PEC  = 4'd8;
  localparam logic [REG_AW-1:0] OFF_AUX  = 4'd13;

  // protocol field, control bits 4:2
  localparam logic [2:0] P_QUICK = 3'd0;
  localparam logic [2:0] P_BYTE  = 3'd1;
  localparam logic [2:0] P_BDATA = 3'd2;
  localparam logic [2:0] P_WORD  = 3'd3;
  localparam logic [2:0] P_BLOCK = 3'd5;

  typedef enum logic [1:0] {OP_START, OP_WRITE, OP_READ, OP_STOP} opKind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CMD, S_RSTART, S_RADDR,
    S_WRITE, S_READ, S_BWAIT, S_PEC, S_STOP
  } seqState_t;

  // strobes from the sequencer into the register datapath
  typedef struct packed {
    logic       setIntr;
    logic       setDevErr;
    logic       setColl;
    logic       setByteDone;
    logic       clrBusy;
    logic       ldData0;
    logic       ldData1;
    logic       ldBlk;
    logic       ldPec;
    logic [7:0] value;
  } seqStrobe_t;

  function automatic logic [7:0] clampCount(input logic [7:0] raw, input int maxLen);
    if (raw == 8'd0) return 8'd1;
    if (int'(raw) > maxLen) return 8'(maxLen);
    return raw;
  endfunction

endpackage

// File: rtl/smbus_host_regs.sv
`timescale 1ns/1ps
module smbus_host_regs
  import smbus_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  seqStrobe_t        strobe,
  output logic              startGo,
  output logic [2:0]        startProto,
  output logic              byteDone,
  output logic [7:0]        addrReg,
  output logic [7:0]        cmdReg,
  output logic [7:0]        data0,
  output logic [7:0]        data1,
  output logic [7:0]        blkReg,
  output logic [7:0]        pecReg,
  output logic              pecEn,
  output logic              lastFlag,
  output logic [7:0]        statusVec
);

  logic busy, intr, devErr, coll, failed;
  logic [5:0] ctlReg;
  logic stsWr, ctlWr, startHit, protoOk;

  assign stsWr      = regWrEn && (regAddr == OFF_STS);
  assign ctlWr      = regWrEn && (regAddr == OFF_CTL);
  assign startProto = regWrData[4:2];
  assign protoOk    = (startProto == P_QUICK) || (startProto == P_BYTE) ||
                      (startProto == P_BDATA) || (startProto == P_WORD) ||
                      (startProto == P_BLOCK);
  assign startHit   = ctlWr && regWrData[6] && !busy && !(devErr || coll || failed);
  assign startGo    = startHit && protoOk;
  assign lastFlag   = ctlReg[5];
  assign statusVec  = {byteDone, 2'b00, failed, coll, devErr, intr, busy};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; intr <= 1'b0; devErr <= 1'b0; coll <= 1'b0;
      failed <= 1'b0; byteDone <= 1'b0;
    end else begin
      if (startGo)             busy <= 1'b1;
      else if (strobe.clrBusy) busy <= 1'b0;
      if (strobe.setIntr)                 intr <= 1'b1;
      else if (stsWr && regWrData[1])     intr <= 1'b0;
      if (strobe.setDevErr)               devErr <= 1'b1;
      else if (stsWr && regWrData[2])     devErr <= 1'b0;
      if (strobe.setColl)                 coll <= 1'b1;
      else if (stsWr && regWrData[3])     coll <= 1'b0;
      if (startHit && !protoOk)           failed <= 1'b1;
      else if (stsWr && regWrData[4])     failed <= 1'b0;
      if (strobe.setByteDone)             byteDone <= 1'b1;
      else if (stsWr && regWrData[7])     byteDone <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= '0; cmdReg <= '0; addrReg <= '0; data0 <= '0;
      data1 <= '0; blkReg <= '0; pecReg <= '0; pecEn <= 1'b0;
    end else begin
      if (ctlWr) ctlReg <= regWrData[5:0];
      if (regWrEn && regAddr == OFF_CMD) cmdReg  <= regWrData;
      if (regWrEn && regAddr == OFF_ADR) addrReg <= regWrData;
      if (regWrEn && regAddr == OFF_AUX) pecEn   <= regWrData[0];
      if (strobe.ldData0)                      data0 <= strobe.value;
      else if (regWrEn && regAddr == OFF_D0)   data0 <= regWrData;
      if (strobe.ldData1)                      data1 <= strobe.value;
      else if (regWrEn && regAddr == OFF_D1)   data1 <= regWrData;
      if (strobe.ldBlk)                        blkReg <= strobe.value;
      else if (regWrEn && regAddr == OFF_BLK)  blkReg <= regWrData;
      if (strobe.ldPec)                        pecReg <= strobe.value;
      else if (regWrEn && regAddr == OFF_PEC)  pecReg <= regWrData;
    end
  end

  always_comb begin
    case (regAddr)
      OFF_STS: regRdData = statusVec;
      OFF_CTL: regRdData = {2'b00, ctlReg};
      OFF_CMD: regRdData = cmdReg;
      OFF_ADR: regRdData = addrReg;
      OFF_D0:  regRdData = data0;
      OFF_D1:  regRdData = data1;
      OFF_BLK: regRdData = blkReg;
      OFF_PEC: regRdData = pecReg;
      OFF_AUX: regRdData = {7'd0, pecEn};
      default: regRdData = 8'd0;
    endcase
  end

endmodule

// File: rtl/smbus_host_seq.sv
`timescale 1ns/1ps
module smbus_host_seq
  import smbus_host_pkg::*;
#(
  parameter int MAX_BLOCK = 32
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startGo,
  input  logic [2:0] startProto,
  input  logic       byteDone,
  input  logic [7:0] addrReg,
  input  logic [7:0] cmdReg,
  input  logic [7:0] data0,
  input  logic [7:0] data1,
  input  logic [7:0] blkReg,
  input  logic [7:0] pecReg,
  input  logic       pecEn,
  input  logic       lastFlag,
  output logic       opValid,
  output opKind_t    opKind,
  output logic [7:0] opTxByte,
  output logic       opNack,
  input  logic       opDone,
  input  logic [7:0] opRxByte,
  input  logic       opAckIn,
  input  logic       opLost,
  output seqStrobe_t strobe
);

  localparam int CNT_W = $clog2(MAX_BLOCK + 1);

  seqState_t  state, nxt, tailSt;
  logic [2:0] proto;
  logic       isRead, usePec, second, endAfter, abortErr;
  logic       nxtSecond, nxtEnd, nxtAbort;
  logic [CNT_W-1:0] remain, nxtRemain;
  logic [7:0] rxClamp, txClamp;
  logic       lastByte;

  assign rxClamp  = clampCount(opRxByte, MAX_BLOCK);
  assign txClamp  = clampCount(data0, MAX_BLOCK);
  assign tailSt   = usePec ? S_PEC : S_STOP;
  assign lastByte = (remain == CNT_W'(1)) || (isRead && lastFlag);

  // request drive, a pure function of the state
  always_comb begin
    opValid  = (state != S_IDLE) && (state != S_BWAIT);
    opKind   = OP_WRITE;
    opTxByte = 8'd0;
    opNack   = 1'b0;
    case (state)
      S_START, S_RSTART: opKind = OP_START;
      S_STOP:            opKind = OP_STOP;
      S_ADDR:   opTxByte = (proto == P_QUICK || proto == P_BYTE) ? addrReg : {addrReg[7:1], 1'b0};
      S_RADDR:  opTxByte = {addrReg[7:1], 1'b1};
      S_CMD:    opTxByte = cmdReg;
      S_WRITE: begin
        if (proto == P_BLOCK)     opTxByte = second ? blkReg : txClamp;
        else if (proto == P_WORD) opTxByte = second ? data1 : data0;
        else                      opTxByte = data0;
      end
      S_READ: begin
        opKind = OP_READ;
        if (proto == P_BLOCK)     opNack = second && lastByte && !usePec;
        else if (proto == P_WORD) opNack = second && !usePec;
        else                      opNack = !usePec;
      end
      S_PEC: begin
        if (isRead) begin opKind = OP_READ; opNack = 1'b1; end
        else        opTxByte = pecReg;
      end
      default: ;
    endcase
  end

  always_comb begin
    strobe = '0;
    strobe.value = opRxByte;
    nxt = state; nxtSecond = second; nxtRemain = remain;
    nxtEnd = endAfter; nxtAbort = abortErr;
    if (state == S_IDLE) begin
      if (startGo) nxt = S_START;
    end else if (state == S_BWAIT) begin
      if (!byteDone) nxt = endAfter ? tailSt : (isRead ? S_READ : S_WRITE);
    end else if (opDone) begin
      if (opLost) begin
        strobe.setColl = 1'b1; strobe.clrBusy = 1'b1; nxt = S_IDLE;
      end else begin
        case (state)
          S_START:  nxt = S_ADDR;
          S_RSTART: nxt = S_RADDR;
          S_ADDR: begin
            if (!opAckIn)               begin nxtAbort = 1'b1; nxt = S_STOP; end
            else if (proto == P_QUICK)  nxt = S_STOP;
            else if (proto == P_BYTE)   nxt = isRead ? S_READ : S_CMD;
            else                        nxt = S_CMD;
          end
          S_CMD: begin
            if (!opAckIn)              begin nxtAbort = 1'b1; nxt = S_STOP; end
            else if (proto == P_BYTE)  nxt = tailSt;
            else                       nxt = isRead ? S_RSTART : S_WRITE;
          end
          S_RADDR: begin
            if (!opAckIn) begin nxtAbort = 1'b1; nxt = S_STOP; end
            else          nxt = S_READ;
          end
          S_WRITE: begin
            if (!opAckIn) begin nxtAbort = 1'b1; nxt = S_STOP; end
            else if (proto == P_BLOCK) begin
              if (!second) begin
                nxtSecond = 1'b1; nxtRemain = CNT_W'(txClamp);
              end else begin
                strobe.setByteDone = 1'b1; nxtEnd = lastByte;
                nxtRemain = remain - CNT_W'(1); nxt = S_BWAIT;
              end
            end else if (proto == P_WORD && !second) nxtSecond = 1'b1;
            else nxt = tailSt;
          end
          S_READ: begin
            if (proto == P_BLOCK) begin
              if (!second) begin
                strobe.ldData0 = 1'b1; strobe.value = rxClamp;
                nxtSecond = 1'b1; nxtRemain = CNT_W'(rxClamp);
              end else begin
                strobe.ldBlk = 1'b1; strobe.setByteDone = 1'b1; nxtEnd = lastByte;
                nxtRemain = remain - CNT_W'(1); nxt = S_BWAIT;
              end
            end else if (proto == P_WORD && second) begin
              strobe.ldData1 = 1'b1; nxt = tailSt;
            end else if (proto == P_WORD) begin
              strobe.ldData0 = 1'b1; nxtSecond = 1'b1;
            end else begin
              strobe.ldData0 = 1'b1; nxt = tailSt;
            end
          end
          S_PEC: begin
            if (isRead)        strobe.ldPec = 1'b1;
            else if (!opAckIn) nxtAbort = 1'b1;
            nxt = S_STOP;
          end
          S_STOP: begin
            strobe.setDevErr = abortErr; strobe.setIntr = !abortErr;
            strobe.clrBusy = 1'b1; nxt = S_IDLE;
          end
          default: nxt = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; proto <= P_QUICK; isRead <= 1'b0; usePec <= 1'b0;
      second <= 1'b0; remain <= '0; endAfter <= 1'b0; abortErr <= 1'b0;
    end else begin
      state <= nxt; second <= nxtSecond; remain <= nxtRemain;
      endAfter <= nxtEnd; abortErr <= nxtAbort;
      if (state == S_IDLE && startGo) begin
        proto    <= startProto;
        isRead   <= addrReg[0];
        usePec   <= pecEn && (startProto != P_QUICK);
        second   <= 1'b0;
        endAfter <= 1'b0;
        abortErr <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/smbus_host.sv
`timescale 1ns/1ps
module smbus_host
  import smbus_host_pkg::*;
#(
  parameter int MAX_BLOCK = 32
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [3:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       opValid,
  output logic [1:0] opKind,
  output logic [7:0] opTxByte,
  output logic       opNack,
  input  logic       opDone,
  input  logic [7:0] opRxByte,
  input  logic       opAckIn,
  input  logic       opLost
);

  seqStrobe_t strobe;
  opKind_t    kindEnum;
  logic       startGo, byteDone, pecEn, lastFlag;
  logic [2:0] startProto;
  logic [7:0] addrReg, cmdReg, data0, data1, blkReg, pecReg, statusVec;

  assign opKind = kindEnum;

  smbus_host_regs u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .startGo(startGo), .startProto(startProto), .byteDone(byteDone),
    .addrReg(addrReg), .cmdReg(cmdReg), .data0(data0), .data1(data1),
    .blkReg(blkReg), .pecReg(pecReg), .pecEn(pecEn), .lastFlag(lastFlag),
    .statusVec(statusVec)
  );

  smbus_host_seq #(.MAX_BLOCK(MAX_BLOCK)) u_seq (
    .clk(clk), .rstN(rstN), .startGo(startGo), .startProto(startProto),
    .byteDone(byteDone), .addrReg(addrReg), .cmdReg(cmdReg), .data0(data0),
    .data1(data1), .blkReg(blkReg), .pecReg(pecReg), .pecEn(pecEn),
    .lastFlag(lastFlag), .opValid(opValid), .opKind(kindEnum),
    .opTxByte(opTxByte), .opNack(opNack), .opDone(opDone),
    .opRxByte(opRxByte), .opAckIn(opAckIn), .opLost(opLost), .strobe(strobe)
  );

endmodule

// File: rtl/smbus_host_chk.sv
`timescale 1ns/1ps
module smbus_host_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] statusVec,
  input logic       opValid,
  input logic [1:0] opKind,
  input logic [7:0] opTxByte,
  input logic       opDone
);

  p_req_hold_r14: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opDone) |=> (opValid && $stable(opKind) && $stable(opTxByte)));

  p_req_needs_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> statusVec[0]);

  p_start_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[0]) |-> (statusVec[4:2] == 3'b000));

  p_done_with_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[1]) |-> $fell(statusVec[0]));

  p_nack_no_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[2]) |-> ($fell(statusVec[0]) && !$rose(statusVec[1])));

  p_coll_ends_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[3]) |-> $fell(statusVec[0]));

  p_pause_in_xfer_r6: assert property (@(posedge clk) disable iff (!rstN)
    statusVec[7] |-> statusVec[0]);

  p_fail_no_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[4]) |-> !statusVec[0]);

endmodule

bind smbus_host smbus_host_chk u_chk (
  .clk(clk), .rstN(rstN), .statusVec(statusVec), .opValid(opValid),
  .opKind(opKind), .opTxByte(opTxByte), .opDone(opDone)
);

// File: tb/test_smbus_host.sv
`timescale 1ns/1ps
module test_smbus_host;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = 4'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       opValid, opNack;
  logic [1:0] opKind;
  logic [7:0] opTxByte;
  logic       opDone = 1'b0;
  logic [7:0] opRxByte = 8'd0;
  logic       opAckIn = 1'b1;
  logic       opLost = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // expected bus operations: kind 0 start, 1 write, 2 read, 3 stop
  int    expKind[$];
  int    expTx[$];
  int    expNack[$];
  string expTag[$];
  bit         ackQ[$];
  logic [7:0] rxQ[$];
  bit    loseNext = 1'b0;
  int    waitCnt = 0;

  always #2.5 clk = ~clk;

  smbus_host i_smbus_host (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .opValid(opValid),
    .opKind(opKind), .opTxByte(opTxByte), .opNack(opNack), .opDone(opDone),
    .opRxByte(opRxByte), .opAckIn(opAckIn), .opLost(opLost)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expOp(string tag, int kind, int tx, int nack);
    expKind.push_back(kind); expTx.push_back(tx);
    expNack.push_back(nack); expTag.push_back(tag);
  endtask

  // behavioural bus engine: completes each request three cycles after it appears
  always @(negedge clk) begin
    automatic bit wasDone = opDone;
    opDone = 1'b0; opLost = 1'b0;
    if (opValid && !wasDone) begin
      waitCnt++;
      if (waitCnt == 3) begin
        waitCnt = 0;
        if (expKind.size() == 0) begin
          check("R2 unexpected bus operation", {30'd0, opKind}, 32'hFFFF);
        end else begin
          automatic int k = expKind.pop_front();
          automatic int t = expTx.pop_front();
          automatic int n = expNack.pop_front();
          automatic string g = expTag.pop_front();
          check({g, " op kind"}, {30'd0, opKind}, k);
          if (k == 1) check({g, " tx byte"}, {24'd0, opTxByte}, t);
          if (k == 2) check({g, " ack/nack"}, {31'd0, opNack}, n);
        end
        opAckIn  = (opKind == 2'd1 && ackQ.size() > 0) ? ackQ.pop_front() : 1'b1;
        opRxByte = (opKind == 2'd2 && rxQ.size() > 0) ? rxQ.pop_front() : 8'hFF;
        opLost   = loseNext;
        loseNext = 1'b0;
        opDone   = 1'b1;
      end
    end else begin
      waitCnt = 0;
    end
  end

  task automatic regWrite(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitStatus(logic [7:0] mask, logic [7:0] want);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      regRead(4'd0, s);
      if ((s & mask) == want) break;
    end
  endtask

  task automatic finishXfer(string tag, logic [7:0] stsExp);
    logic [7:0] s;
    waitStatus(8'h01, 8'h00);
    regRead(4'd0, s);
    check({tag, " final status"}, {24'd0, s}, {24'd0, stsExp});
    check({tag, " all ops issued"}, expKind.size(), 0);
    regWrite(4'd0, 8'h9E);
  endtask

  logic [7:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values and readback
    regRead(4'd0, rd);  check("R1 status after reset", rd, 8'h00);
    regRead(4'd5, rd);  check("R1 data0 after reset", rd, 8'h00);
    regWrite(4'd3, 8'h5A); regRead(4'd3, rd); check("R1 command readback", rd, 8'h5A);
    regWrite(4'd13, 8'hFF); regRead(4'd13, rd); check("R1 aux keeps bit0 only", rd, 8'h01);
    regWrite(4'd13, 8'h00);
    regWrite(4'd2, 8'h34); regRead(4'd2, rd); check("R1 control readback", rd, 8'h34);

    // R3: quick write to 0x50
    regWrite(4'd4, 8'hA0);
    expOp("R3", 0, 0, 0); expOp("R3", 1, 8'hA0, 0); expOp("R3", 3, 0, 0);
    regWrite(4'd2, 8'h40);
    finishXfer("R3 R9 quick", 8'h02);

    // R4: byte read, then byte write
    regWrite(4'd4, 8'hA3); rxQ.push_back(8'h5C);
    expOp("R4", 0, 0, 0); expOp("R4", 1, 8'hA3, 0); expOp("R4", 2, 0, 1); expOp("R4", 3, 0, 0);
    regWrite(4'd2, 8'h44);
    finishXfer("R4 byte read", 8'h02);
    regRead(4'd5, rd); check("R4 byte read into data0", rd, 8'h5C);
    regWrite(4'd4, 8'hA2); regWrite(4'd3, 8'h6B);
    expOp("R4", 0, 0, 0); expOp("R4", 1, 8'hA2, 0); expOp("R4", 1, 8'h6B, 0); expOp("R4", 3, 0, 0);
    regWrite(4'd2, 8'h44);
    finishXfer("R4 byte write", 8'h02);

    // R5: byte-data write and word read
    regWrite(4'd4, 8'hA0); regWrite(4'd3, 8'h12); regWrite(4'd5, 8'h34);
    expOp("R5", 0, 0, 0); expOp("R5", 1, 8'hA0, 0); expOp("R5", 1, 8'h12, 0);
    expOp("R5", 1, 8'h34, 0); expOp("R5", 3, 0, 0);
    regWrite(4'd2, 8'h48);
    finishXfer("R5 byte-data write", 8'h02);
    regWrite(4'd4, 8'hA1); regWrite(4'd3, 8'h07);
    rxQ.push_back(8'h11); rxQ.push_back(8'h22);
    expOp("R5", 0, 0, 0); expOp("R5", 1, 8'hA0, 0); expOp("R5", 1, 8'h07, 0);
    expOp("R5", 0, 0, 0); expOp("R5", 1, 8'hA1, 0); expOp("R5", 2, 0, 0);
    expOp("R5", 2, 0, 1); expOp("R5", 3, 0, 0);
    regWrite(4'd2, 8'h4C);
    finishXfer("R5 word read", 8'h02);
    regRead(4'd5, rd); check("R5 word low in data0", rd, 8'h11);
    regRead(4'd6, rd); check("R5 word high in data1", rd, 8'h22);

    // R10: address NACK, then R2: start refused while error pending, then R8
    regWrite(4'd4, 8'hA0); ackQ.push_back(1'b0);
    expOp("R10", 0, 0, 0); expOp("R10", 1, 8'hA0, 0); expOp("R10", 3, 0, 0);
    regWrite(4'd2, 8'h40);
    waitStatus(8'h01, 8'h00);
    regRead(4'd0, rd); check("R10 device error without complete", rd, 8'h04);
    regWrite(4'd2, 8'h40);
    repeat (10) @(negedge clk);
    regRead(4'd0, rd); check("R2 start refused while error set", rd, 8'h04);
    regWrite(4'd0, 8'h01);
    regRead(4'd0, rd); check("R8 busy bit not clearable", rd, 8'h04);
    regWrite(4'd0, 8'h04);
    regRead(4'd0, rd); check("R8 device error cleared by one", rd, 8'h00);

    // R12: unsupported protocol code 0x10
    regWrite(4'd2, 8'h50);
    repeat (6) @(negedge clk);
    regRead(4'd0, rd); check("R12 failed flag, not busy", rd, 8'h10);
    regWrite(4'd0, 8'h10);

    // R11: arbitration lost on the start operation
    loseNext = 1'b1; expOp("R11", 0, 0, 0);
    regWrite(4'd2, 8'h40);
    finishXfer("R11 collision", 8'h08);

    // R6: block write, count 3, with start attempt while paused (R2)
    regWrite(4'd4, 8'hA0); regWrite(4'd3, 8'h33); regWrite(4'd5, 8'h03); regWrite(4'd7, 8'hB0);
    expOp("R6", 0, 0, 0); expOp("R6", 1, 8'hA0, 0); expOp("R6", 1, 8'h33, 0);
    expOp("R6", 1, 8'h03, 0); expOp("R6", 1, 8'hB0, 0);
    regWrite(4'd2, 8'h54);
    for (int k = 1; k <= 3; k++) begin
      waitStatus(8'h80, 8'h80);
      regRead(4'd0, rd); check("R6 paused with byte-done and busy", rd, 8'h81);
      if (k == 1) begin
        regWrite(4'd2, 8'h40);
        regRead(4'd0, rd); check("R2 start refused while busy", rd, 8'h81);
      end
      if (k < 3) begin
        regWrite(4'd7, 8'(8'hB0 + k));
        expOp("R6", 1, 8'hB0 + k, 0);
      end else expOp("R6", 3, 0, 0);
      regWrite(4'd0, 8'h80);
    end
    finishXfer("R6 block write", 8'h02);

    // R6: count 0 clamps to 1, count 40 clamps to 32
    regWrite(4'd5, 8'h00); regWrite(4'd7, 8'hC1);
    expOp("R6 clamp0", 0, 0, 0); expOp("R6 clamp0", 1, 8'hA0, 0); expOp("R6 clamp0", 1, 8'h33, 0);
    expOp("R6 clamp0", 1, 8'h01, 0); expOp("R6 clamp0", 1, 8'hC1, 0);
    regWrite(4'd2, 8'h54);
    waitStatus(8'h80, 8'h80);
    expOp("R6 clamp0", 3, 0, 0);
    regWrite(4'd0, 8'h80);
    finishXfer("R6 count zero", 8'h02);
    regWrite(4'd5, 8'd40); regWrite(4'd7, 8'h00);
    expOp("R6 clamp40", 0, 0, 0); expOp("R6 clamp40", 1, 8'hA0, 0); expOp("R6 clamp40", 1, 8'h33, 0);
    expOp("R6 clamp40", 1, 8'h20, 0); expOp("R6 clamp40", 1, 8'h00, 0);
    regWrite(4'd2, 8'h54);
    for (int k = 1; k <= 32; k++) begin
      waitStatus(8'h80, 8'h80);
      if (k < 32) begin
        regWrite(4'd7, 8'(k));
        expOp("R6 clamp40", 1, k, 0);
      end else expOp("R6 clamp40", 3, 0, 0);
      regWrite(4'd0, 8'h80);
    end
    finishXfer("R6 count forty", 8'h02);

    // R7: block read, count 3, last flag set before the third byte
    regWrite(4'd4, 8'hA1); regWrite(4'd3, 8'h44);
    rxQ.push_back(8'd3); rxQ.push_back(8'hD1); rxQ.push_back(8'hD2); rxQ.push_back(8'hD3);
    expOp("R7", 0, 0, 0); expOp("R7", 1, 8'hA0, 0); expOp("R7", 1, 8'h44, 0);
    expOp("R7", 0, 0, 0); expOp("R7", 1, 8'hA1, 0); expOp("R7", 2, 0, 0); expOp("R7", 2, 0, 0);
    regWrite(4'd2, 8'h54);
    for (int k = 1; k <= 3; k++) begin
      waitStatus(8'h80, 8'h80);
      regRead(4'd7, rd); check("R7 block byte in port", rd, 8'(8'hD0 + k));
      if (k == 1) begin regRead(4'd5, rd); check("R7 count in data0", rd, 8'd3); end
      if (k == 2) regWrite(4'd2, 8'h34);
      if (k < 3) expOp("R7", 2, 0, (k == 2) ? 1 : 0);
      else       expOp("R7", 3, 0, 0);
      regWrite(4'd0, 8'h80);
    end
    finishXfer("R7 block read", 8'h02);

    // R7: count 50 clamps to 32, software ends after two bytes via last flag
    rxQ.push_back(8'd50); rxQ.push_back(8'hE1); rxQ.push_back(8'hE2);
    expOp("R7 early", 0, 0, 0); expOp("R7 early", 1, 8'hA0, 0); expOp("R7 early", 1, 8'h44, 0);
    expOp("R7 early", 0, 0, 0); expOp("R7 early", 1, 8'hA1, 0); expOp("R7 early", 2, 0, 0);
    expOp("R7 early", 2, 0, 0);
    regWrite(4'd2, 8'h54);
    waitStatus(8'h80, 8'h80);
    regRead(4'd5, rd); check("R7 count 50 clamped to 32", rd, 8'd32);
    regWrite(4'd2, 8'h34);
    expOp("R7 early", 2, 0, 1);
    regWrite(4'd0, 8'h80);
    waitStatus(8'h80, 8'h80);
    regRead(4'd7, rd); check("R7 second byte", rd, 8'hE2);
    expOp("R7 early", 3, 0, 0);
    regWrite(4'd0, 8'h80);
    finishXfer("R7 early end", 8'h02);

    // R7: count 0 clamps to 1; the single byte is NACKed by count
    rxQ.push_back(8'd0); rxQ.push_back(8'hF5);
    expOp("R7 one", 0, 0, 0); expOp("R7 one", 1, 8'hA0, 0); expOp("R7 one", 1, 8'h44, 0);
    expOp("R7 one", 0, 0, 0); expOp("R7 one", 1, 8'hA1, 0); expOp("R7 one", 2, 0, 0);
    expOp("R7 one", 2, 0, 1);
    regWrite(4'd2, 8'h54);
    waitStatus(8'h80, 8'h80);
    regRead(4'd5, rd); check("R7 count zero clamped to 1", rd, 8'd1);
    expOp("R7 one", 3, 0, 0);
    regWrite(4'd0, 8'h80);
    finishXfer("R7 single byte", 8'h02);

    // R13: PEC appended on a byte-data write and received on a byte read
    regWrite(4'd13, 8'h01); regWrite(4'd8, 8'h9E);
    regWrite(4'd4, 8'hA0); regWrite(4'd3, 8'h12); regWrite(4'd5, 8'h34);
    expOp("R13", 0, 0, 0); expOp("R13", 1, 8'hA0, 0); expOp("R13", 1, 8'h12, 0);
    expOp("R13", 1, 8'h34, 0); expOp("R13", 1, 8'h9E, 0); expOp("R13", 3, 0, 0);
    regWrite(4'd2, 8'h48);
    finishXfer("R13 pec write", 8'h02);
    regWrite(4'd4, 8'hA3); rxQ.push_back(8'h44); rxQ.push_back(8'hE7);
    expOp("R13", 0, 0, 0); expOp("R13", 1, 8'hA3, 0); expOp("R13", 2, 0, 0);
    expOp("R13", 2, 0, 1); expOp("R13", 3, 0, 0);
    regWrite(4'd2, 8'h44);
    finishXfer("R13 pec read", 8'h02);
    regRead(4'd5, rd); check("R13 data byte", rd, 8'h44);
    regRead(4'd8, rd); check("R13 pec byte received", rd, 8'hE7);
    regWrite(4'd13, 8'h00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule